// File: doc/BRIEF.md
# Power-Management Mailbox Responder

This block is a memory-mapped mailbox between a host processor and a power-management agent. The agent is replaced by a small hardware responder. The host uses a 32-bit register bus with word addresses. It loads a command word and up to four argument words, then rings a doorbell. The responder checks the request against its operating-point rules. It writes any result words back into the argument registers, posts a status code, returns the command register to zero and raises a one-cycle completion interrupt.

The responder keeps an operating-point map. The map is a mode, two divider words and a starting performance level, and it may be loaded only once. It also keeps the current performance level, from 0 to 4. A set of frequency entries, one per level and written by the host, supplies the value shown in the frequency register whenever the level changes.

Back-pressure: neither the register bus nor the doorbell has a ready signal. Every bus access completes in the cycle it is presented, with read data valid in that same cycle. A doorbell that arrives while a command is running is dropped.

Top module: `pm_mailbox_responder`

## Requirements
- R1: After reset, the command, status, argument, level and frequency registers read 0 and the interrupt is low. A read of word 13 always returns 0xA11600D1.
- R2: The host can write and read back word 0 (command), word 1 (status) and words 6 to 9 (arguments 0 to 3). Writes to word 11 (level), word 13 (magic) and word 20 (frequency) have no effect. Words 48 to 52 hold the frequency entries for levels 0 to 4 and can be written and read.
- R3: A doorbell write with bit 31 set starts the pending command. The status register and the interrupt both change at the second clock edge after the doorbell is sampled. A doorbell write with bit 31 clear does nothing.
- R4: The completion interrupt is high for exactly one cycle per command.
- R5: The command register reads 0 once a command has completed.
- R6: Opcodes 0x00 and 0x10 to 0x18 complete with status 0xF0 and leave all other registers unchanged.
- R7: Any other command word, including one with bits above bit 7 set, completes with status 0xF1 and leaves all other registers unchanged.
- R8: Opcode 0x31 with argument 0 (mode) at most 3 and argument 3 (starting level) at most 4 stores the map, moves the level to the starting level, loads the frequency register from that level's entry, and reports 0xF0.
- R9: Once a map is stored, opcode 0x31 reports 0xF4 and changes nothing.
- R10: Opcode 0x31 with a mode above 3 reports 0xF2. With a valid mode and a starting level above 4 it reports 0xFF. Neither stores a map.
- R11: Opcode 0x30 reports 0xF0 and returns mode, divider word 1, divider word 2 and starting level in arguments 0 to 3.
- R12: Opcode 0x41 issued before any map is stored reports 0xF3 and leaves the level at 0.
- R13: Opcode 0x41 with argument 0 at most 4 sets the level and loads the frequency register from that level's entry. With argument 0 above 4 it reports 0xFF and leaves the level and frequency unchanged.
- R14: Opcode 0x40 reports 0xF0 and returns the current level in argument 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| dbell_wr | input | 1 | Write strobe for the doorbell register |
| dbell_data | input | 32 | Doorbell data; bit 31 starts a command |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The checks assume that the host leaves the command, status and argument registers alone during the one cycle in which a command runs. They also assume that the host rings the doorbell only when no command is in flight. The stimulus follows the host protocol. It clears the status, writes the command and then rings the doorbell. It waits for the interrupt and its trailing low cycle before the next bus access, so every engine commit lands on a quiet bus. Under these conditions the assertions hold. The interrupt follows the run cycle and never repeats. The command register is zero whenever the interrupt is high. The level stays in range, and it stays at zero until a map exists.

// File: rtl/pmbx_pkg.sv
package pmbx_pkg;

  localparam logic [31:0] MAGIC_WORD = 32'hA116_00D1;

  // word addresses that the host protocol depends on
  localparam int unsigned WA_CMD    = 0;
  localparam int unsigned WA_STATUS = 1;
  localparam int unsigned WA_PARAM0 = 6;
  localparam int unsigned WA_LEVEL  = 11;
  localparam int unsigned WA_MAGIC  = 13;
  localparam int unsigned WA_FREQ   = 20;

  // opcodes
  localparam logic [7:0] OP_AVAIL    = 8'h00;
  localparam logic [7:0] OP_DISABLE  = 8'h10;
  localparam logic [7:0] OP_ENABLE   = 8'h11;
  localparam logic [7:0] OP_S2_IN    = 8'h12;
  localparam logic [7:0] OP_S2_OUT   = 8'h13;
  localparam logic [7:0] OP_BBM_IN   = 8'h14;
  localparam logic [7:0] OP_BBM_OUT  = 8'h15;
  localparam logic [7:0] OP_S3_IN    = 8'h16;
  localparam logic [7:0] OP_S3_OUT   = 8'h17;
  localparam logic [7:0] OP_BALANCE  = 8'h18;
  localparam logic [7:0] OP_MAP_GET  = 8'h30;
  localparam logic [7:0] OP_MAP_SET  = 8'h31;
  localparam logic [7:0] OP_LVL_GET  = 8'h40;
  localparam logic [7:0] OP_LVL_SET  = 8'h41;

  // status codes
  typedef logic [7:0] status_t;
  localparam status_t ST_CLEAR   = 8'h00;
  localparam status_t ST_OK      = 8'hF0;
  localparam status_t ST_BADCMD  = 8'hF1;
  localparam status_t ST_NOSUPP  = 8'hF2;
  localparam status_t ST_NOMAP   = 8'hF3;
  localparam status_t ST_MAPSET  = 8'hF4;
  localparam status_t ST_FAIL    = 8'hFF;

  localparam logic [31:0] MODE_MAX = 32'd3;

  typedef struct packed {
    logic [31:0] mode;
    logic [31:0] div_a;
    logic [31:0] div_b;
    logic [31:0] start_lvl;
  } opmap_t;

endpackage

// File: rtl/pmbx_doorbell.sv
module pmbx_doorbell #(
  parameter int DATA_W   = 32,
  parameter int RING_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_wr,
  input  logic [DATA_W-1:0] ring_data,
  output logic              run_o
);

  typedef enum logic {DB_IDLE, DB_RUN} db_state_e;
  db_state_e state_q, state_d;

  logic ring_hit;
  logic unused_ring_bits;

  assign ring_hit = ring_wr && ring_data[RING_BIT];
  assign unused_ring_bits = ^ring_data;

  always_comb begin
    state_d = DB_IDLE;
    if (state_q == DB_IDLE && ring_hit) state_d = DB_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DB_IDLE;
    else        state_q <= state_d;
  end

  assign run_o = (state_q == DB_RUN);

endmodule

// File: rtl/pmbx_freq_table.sv
module pmbx_freq_table #(
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 5,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  bus_idx,
  output logic [DATA_W-1:0] bus_data,
  input  logic [IDX_W-1:0]  look_idx,
  output logic [DATA_W-1:0] look_data
);

  logic [DATA_W-1:0] entry_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   entry_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))        entry_q[g] <= wr_data;
    end
  end

  always_comb begin
    bus_data  = '0;
    look_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (bus_idx == IDX_W'(i))  bus_data  = entry_q[i];
      if (look_idx == IDX_W'(i)) look_data = entry_q[i];
    end
  end

endmodule

// File: rtl/pmbx_exec.sv
module pmbx_exec
  import pmbx_pkg::*;
#(
  parameter int NUM_PARAMS = 4,
  parameter int NUM_LVLS   = 5,
  localparam int LVL_W     = (NUM_LVLS > 1) ? $clog2(NUM_LVLS) : 1
) (
  input  logic [31:0]                  cmd_i,
  input  logic [NUM_PARAMS-1:0][31:0]  params_i,
  input  logic                         map_valid_i,
  input  opmap_t                       map_i,
  input  logic [LVL_W-1:0]             lvl_i,
  output status_t                      status_o,
  output logic                         params_wr_o,
  output logic [NUM_PARAMS-1:0][31:0]  params_o,
  output logic                         map_wr_o,
  output opmap_t                       map_o,
  output logic                         lvl_wr_o,
  output logic [LVL_W-1:0]             lvl_o
);

  localparam logic [31:0] LVL_MAX = 32'(NUM_LVLS - 1);

  always_comb begin
    status_o    = ST_BADCMD;
    params_wr_o = 1'b0;
    params_o    = params_i;
    map_wr_o    = 1'b0;
    map_o.mode      = params_i[0];
    map_o.div_a     = params_i[1];
    map_o.div_b     = params_i[2];
    map_o.start_lvl = params_i[3];
    lvl_wr_o    = 1'b0;
    lvl_o       = lvl_i;

    if (cmd_i[31:8] == 24'd0) begin
      case (cmd_i[7:0])
        OP_AVAIL, OP_DISABLE, OP_ENABLE, OP_S2_IN, OP_S2_OUT,
        OP_BBM_IN, OP_BBM_OUT, OP_S3_IN, OP_S3_OUT, OP_BALANCE: begin
          status_o = ST_OK;
        end
        OP_MAP_GET: begin
          status_o    = ST_OK;
          params_wr_o = 1'b1;
          params_o[0] = map_i.mode;
          params_o[1] = map_i.div_a;
          params_o[2] = map_i.div_b;
          params_o[3] = map_i.start_lvl;
        end
        OP_MAP_SET: begin
          if (map_valid_i)                 status_o = ST_MAPSET;
          else if (params_i[0] > MODE_MAX) status_o = ST_NOSUPP;
          else if (params_i[3] > LVL_MAX)  status_o = ST_FAIL;
          else begin
            status_o = ST_OK;
            map_wr_o = 1'b1;
            lvl_wr_o = 1'b1;
            lvl_o    = params_i[3][LVL_W-1:0];
          end
        end
        OP_LVL_GET: begin
          status_o    = ST_OK;
          params_wr_o = 1'b1;
          params_o[0] = 32'(lvl_i);
        end
        OP_LVL_SET: begin
          if (!map_valid_i)               status_o = ST_NOMAP;
          else if (params_i[0] > LVL_MAX) status_o = ST_FAIL;
          else begin
            status_o = ST_OK;
            lvl_wr_o = 1'b1;
            lvl_o    = params_i[0][LVL_W-1:0];
          end
        end
        default: status_o = ST_BADCMD;
      endcase
    end
  end

endmodule

// File: rtl/pm_mailbox_responder.sv
module pm_mailbox_responder
  import pmbx_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int NUM_PARAMS = 4,
  parameter int NUM_LVLS   = 5,
  parameter int FREQ_BASE  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbell_wr,
  input  logic [31:0]       dbell_data,
  output logic              done_irq
);

  localparam int LVL_W = (NUM_LVLS > 1) ? $clog2(NUM_LVLS) : 1;
  localparam logic [ADDR_W-1:0] LUT_LO = ADDR_W'(FREQ_BASE);
  localparam logic [ADDR_W-1:0] LUT_HI = ADDR_W'(FREQ_BASE + NUM_LVLS);

  logic [31:0]                 cmd_q;
  logic [31:0]                 status_q;
  logic [NUM_PARAMS-1:0][31:0] param_q;
  logic [LVL_W-1:0]            lvl_q;
  logic [31:0]                 freq_q;
  opmap_t                      map_q;
  logic                        map_valid_q;

  logic host_wr, in_lut, busy;
  logic [LVL_W-1:0] lut_idx;
  logic [31:0] lut_bus_rd, lut_look_rd;

  status_t                     ex_status;
  logic                        ex_params_wr, ex_map_wr, ex_lvl_wr;
  logic [NUM_PARAMS-1:0][31:0] ex_params;
  opmap_t                      ex_map;
  logic [LVL_W-1:0]            ex_lvl;

  assign host_wr = bus_sel && bus_wr;
  assign in_lut  = (bus_addr >= LUT_LO) && (bus_addr < LUT_HI);
  assign lut_idx = LVL_W'(bus_addr - LUT_LO);

  pmbx_doorbell #(.DATA_W(32), .RING_BIT(31)) u_dbell (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_wr   (dbell_wr),
    .ring_data (dbell_data),
    .run_o     (busy)
  );

  pmbx_freq_table #(.DATA_W(32), .ENTRIES(NUM_LVLS)) u_ftab (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_wr && in_lut),
    .wr_idx    (lut_idx),
    .wr_data   (bus_wdata),
    .bus_idx   (lut_idx),
    .bus_data  (lut_bus_rd),
    .look_idx  (ex_lvl),
    .look_data (lut_look_rd)
  );

  pmbx_exec #(.NUM_PARAMS(NUM_PARAMS), .NUM_LVLS(NUM_LVLS)) u_exec (
    .cmd_i       (cmd_q),
    .params_i    (param_q),
    .map_valid_i (map_valid_q),
    .map_i       (map_q),
    .lvl_i       (lvl_q),
    .status_o    (ex_status),
    .params_wr_o (ex_params_wr),
    .params_o    (ex_params),
    .map_wr_o    (ex_map_wr),
    .map_o       (ex_map),
    .lvl_wr_o    (ex_lvl_wr),
    .lvl_o       (ex_lvl)
  );

  // command and status: engine commit has priority over host writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      status_q <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= busy;
      if (busy) begin
        cmd_q    <= '0;
        status_q <= 32'(ex_status);
      end else if (host_wr) begin
        if (bus_addr == ADDR_W'(WA_CMD))    cmd_q    <= bus_wdata;
        if (bus_addr == ADDR_W'(WA_STATUS)) status_q <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_param
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        param_q[g] <= '0;
      else if (busy) begin
        if (ex_params_wr) param_q[g] <= ex_params[g];
      end else if (host_wr && bus_addr == ADDR_W'(WA_PARAM0 + g))
        param_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q       <= '0;
      freq_q      <= '0;
      map_q       <= '0;
      map_valid_q <= 1'b0;
    end else if (busy) begin
      if (ex_lvl_wr) begin
        lvl_q  <= ex_lvl;
        freq_q <= lut_look_rd;
      end
      if (ex_map_wr) begin
        map_q       <= ex_map;
        map_valid_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == ADDR_W'(WA_CMD))    bus_rdata = cmd_q;
      if (bus_addr == ADDR_W'(WA_STATUS)) bus_rdata = status_q;
      if (bus_addr == ADDR_W'(WA_LEVEL))  bus_rdata = 32'(lvl_q);
      if (bus_addr == ADDR_W'(WA_MAGIC))  bus_rdata = MAGIC_WORD;
      if (bus_addr == ADDR_W'(WA_FREQ))   bus_rdata = freq_q;
      for (int i = 0; i < NUM_PARAMS; i++)
        if (bus_addr == ADDR_W'(WA_PARAM0 + i)) bus_rdata = param_q[i];
      if (in_lut) bus_rdata = lut_bus_rd;
    end
  end

endmodule

// File: rtl/pmbx_checker.sv
module pmbx_checker
  import pmbx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LVL_W  = 3,
  parameter int MAX_LVL = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              busy,
  input logic              done_irq,
  input logic [31:0]       cmd,
  input logic [31:0]       status,
  input logic [LVL_W-1:0]  lvl,
  input logic              map_valid
);

  AST_MAGIC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(WA_MAGIC)) |-> (bus_rdata == MAGIC_WORD)); // R1
  AST_RUN_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done_irq); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(busy)); // R3
  AST_STATUS_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (status[7:0] >= ST_OK)); // R3
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq); // R4
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (cmd == 32'd0)); // R5
  AST_MAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |=> map_valid); // R9
  AST_LVL_NEEDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    !map_valid |-> (lvl == '0)); // R12
  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(lvl) <= 32'(MAX_LVL)); // R13

endmodule

bind pm_mailbox_responder pmbx_checker #(
  .ADDR_W (ADDR_W),
  .LVL_W  (LVL_W),
  .MAX_LVL(NUM_LVLS - 1)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .done_irq  (done_irq),
  .cmd       (cmd_q),
  .status    (status_q),
  .lvl       (lvl_q),
  .map_valid (map_valid_q)
);

// File: tb/pm_mailbox_responder_tb.sv
module pm_mailbox_responder_tb;

  localparam int A_CMD = 0, A_ST = 1, A_P0 = 6, A_LVL = 11, A_MAGIC = 13, A_FREQ = 20, A_LUT = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbell_wr = 1'b0;
  logic [31:0] dbell_data = '0;
  logic        done_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pm_mailbox_responder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbell_wr(dbell_wr), .dbell_data(dbell_data), .done_irq(done_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'(a);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // full host protocol: clear status, load command, ring, await completion
  task automatic run_cmd(input logic [31:0] op, input logic [7:0] exp_st, input string req);
    wr(A_ST, 32'd0);
    wr(A_CMD, op);
    @(negedge clk);
    dbell_wr = 1'b1; dbell_data = 32'h8000_0000;
    @(negedge clk);
    dbell_wr = 1'b0; dbell_data = '0;
    chk({req, " R3 irq low during run"}, 32'(done_irq), 32'd0);
    @(negedge clk);
    chk({req, " R3 irq at completion"}, 32'(done_irq), 32'd1);
    @(negedge clk);
    chk({req, " R4 irq single cycle"}, 32'(done_irq), 32'd0);
    rd_chk({req, " status"}, A_ST, 32'(exp_st));
    rd_chk({req, " R5 command cleared"}, A_CMD, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(done_irq), 32'd0);
    rd_chk("R1 command", A_CMD, 32'd0);
    rd_chk("R1 status", A_ST, 32'd0);
    for (int i = 0; i < 4; i++) rd_chk("R1 param", A_P0 + i, 32'd0);
    rd_chk("R1 level", A_LVL, 32'd0);
    rd_chk("R1 freq", A_FREQ, 32'd0);
    rd_chk("R1 magic", A_MAGIC, 32'hA116_00D1);
  endtask

  task automatic t_bus;
    for (int i = 0; i < 4; i++) wr(A_P0 + i, 32'h1111_0000 + 32'(i));
    for (int i = 0; i < 4; i++) rd_chk("R2 param readback", A_P0 + i, 32'h1111_0000 + 32'(i));
    wr(A_ST, 32'h0000_00AB);
    rd_chk("R2 status readback", A_ST, 32'h0000_00AB);
    wr(A_LVL, 32'd3);
    wr(A_MAGIC, 32'd0);
    wr(A_FREQ, 32'hDEAD);
    rd_chk("R2 level read-only", A_LVL, 32'd0);
    rd_chk("R2 magic read-only", A_MAGIC, 32'hA116_00D1);
    rd_chk("R2 freq read-only", A_FREQ, 32'd0);
    for (int i = 0; i < 5; i++) wr(A_LUT + i, 32'd1000 + 32'd100 * 32'(i));
    for (int i = 0; i < 5; i++) rd_chk("R2 freq entry", A_LUT + i, 32'd1000 + 32'd100 * 32'(i));
  endtask

  task automatic t_no_ring;
    wr(A_ST, 32'd0);
    wr(A_CMD, 32'h10);
    @(negedge clk);
    dbell_wr = 1'b1; dbell_data = 32'h7FFF_FFFF;
    @(negedge clk);
    dbell_wr = 1'b0; dbell_data = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 no start without bit 31", 32'(done_irq), 32'd0);
    end
    rd_chk("R3 command kept", A_CMD, 32'h10);
    rd_chk("R3 status untouched", A_ST, 32'd0);
  endtask

  task automatic t_simple;
    logic [7:0] ops [10] = '{8'h00, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h17, 8'h18};
    for (int i = 0; i < 4; i++) wr(A_P0 + i, 32'hA0 + 32'(i));
    for (int k = 0; k < 10; k++) run_cmd(32'(ops[k]), 8'hF0, "R6");
    for (int i = 0; i < 4; i++) rd_chk("R6 params unchanged", A_P0 + i, 32'hA0 + 32'(i));
    rd_chk("R6 level unchanged", A_LVL, 32'd0);
  endtask

  task automatic t_unknown;
    run_cmd(32'h20, 8'hF1, "R7");
    run_cmd(32'h0000_0141, 8'hF1, "R7 upper bits");
    run_cmd(32'h32, 8'hF1, "R7");
    for (int i = 0; i < 4; i++) rd_chk("R7 params unchanged", A_P0 + i, 32'hA0 + 32'(i));
    rd_chk("R7 freq unchanged", A_FREQ, 32'd0);
  endtask

  task automatic t_no_map;
    wr(A_P0, 32'd2);
    run_cmd(32'h41, 8'hF3, "R12");
    rd_chk("R12 level stays 0", A_LVL, 32'd0);
  endtask

  task automatic t_bad_map;
    wr(A_P0, 32'd4); wr(A_P0 + 3, 32'd1);
    run_cmd(32'h31, 8'hF2, "R10 bad mode");
    wr(A_P0, 32'd3); wr(A_P0 + 3, 32'd5);
    run_cmd(32'h31, 8'hF1 + 8'h0E, "R10 bad start level");
    wr(A_P0, 32'd1);
    run_cmd(32'h41, 8'hF3, "R10 no map stored");
  endtask

  task automatic t_set_map;
    wr(A_P0, 32'd3); wr(A_P0 + 1, 32'h0012_3456); wr(A_P0 + 2, 32'h0403_0201); wr(A_P0 + 3, 32'd2);
    run_cmd(32'h31, 8'hF0, "R8");
    rd_chk("R8 level from map", A_LVL, 32'd2);
    rd_chk("R8 freq from entry", A_FREQ, 32'd1200);
    for (int i = 0; i < 4; i++) wr(A_P0 + i, 32'd0);
    run_cmd(32'h30, 8'hF0, "R11");
    rd_chk("R11 mode", A_P0, 32'd3);
    rd_chk("R11 divider a", A_P0 + 1, 32'h0012_3456);
    rd_chk("R11 divider b", A_P0 + 2, 32'h0403_0201);
    rd_chk("R11 start level", A_P0 + 3, 32'd2);
  endtask

  task automatic t_map_again;
    wr(A_P0, 32'd0); wr(A_P0 + 1, 32'h5); wr(A_P0 + 2, 32'h6); wr(A_P0 + 3, 32'd0);
    run_cmd(32'h31, 8'hF4, "R9");
    rd_chk("R9 level unchanged", A_LVL, 32'd2);
    run_cmd(32'h30, 8'hF0, "R9 readback");
    rd_chk("R9 map kept", A_P0 + 1, 32'h0012_3456);
  endtask

  task automatic t_levels;
    wr(A_P0, 32'd4);
    run_cmd(32'h41, 8'hF0, "R13 top level");
    rd_chk("R13 level 4", A_LVL, 32'd4);
    rd_chk("R13 freq 4", A_FREQ, 32'd1400);
    wr(A_P0, 32'd5);
    run_cmd(32'h41, 8'hFF, "R13 out of range");
    rd_chk("R13 level kept", A_LVL, 32'd4);
    rd_chk("R13 freq kept", A_FREQ, 32'd1400);
    wr(A_LUT, 32'd777);
    wr(A_P0, 32'd0);
    run_cmd(32'h41, 8'hF0, "R13 level 0");
    rd_chk("R13 freq 0 new entry", A_FREQ, 32'd777);
    wr(A_P0, 32'hFFFF);
    run_cmd(32'h40, 8'hF0, "R14");
    rd_chk("R14 level returned", A_P0, 32'd0);
    wr(A_P0, 32'd3);
    run_cmd(32'h41, 8'hF0, "R13 level 3");
    run_cmd(32'h40, 8'hF0, "R14");
    rd_chk("R14 level 3 returned", A_P0, 32'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bus();
    t_no_ring();
    t_simple();
    t_unknown();
    t_no_map();
    t_bad_map();
    t_set_map();
    t_map_again();
    t_levels();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule